// File: doc/BRIEF.md
# Halfword-to-word register access bridge

This bridge lets a host that issues 16-bit transfers reach a register file that only handles full 32-bit reads and writes. It joins two halfword writes into one downstream word write. It serves two halfword reads from one downstream word read. Full-word host transfers pass straight through. Byte transfers are refused.

Halfwords are paired by counting transfers that fall in the same aligned word. Their order does not matter. On the read side, the first halfword read of a pair takes a snapshot of the whole register. Both halves therefore come from a single atomic 32-bit read, even if the register changes in between.

Downstream requests are single-cycle strobes issued combinationally in the same cycle as the host transfer. Downstream read data returns to the host in that same cycle.

Top module: `hw_pair_bridge`

## Requirements
- R1: Only `host_addr[7:0]` is significant; higher address bits are ignored. Every downstream request carries `host_addr[7:2]` with bits 1:0 forced to zero.
- R2: For halfword transfers, `host_addr[1]`=0 selects bits 15:0 of the register and `host_addr[1]`=1 selects bits 31:16. Halfword data travels on bits 15:0 of `host_wdata` and `host_rdata`, and the upper 16 bits of `host_rdata` read as zero.
- R3: A halfword write (`host_size`=2'b01, `host_write`=1) stores its data into a low or high holding half chosen by `host_addr[1]`. The first write of a pair issues nothing downstream. The second write to the same aligned word issues one write whose data is {high hold, low hold}, using the holds as they stand after that second write. Two writes to the same half also form a pair.
- R4: A halfword transfer whose aligned address differs from the previous halfword transfer of the same direction restarts that direction's pairing. That transfer then counts as the first of a new pair.
- R5: The first halfword read of a pair (`host_write`=0) issues one downstream read and latches the word. The second issues no downstream read and returns its half from the latch, even if the register has changed meanwhile.
- R6: A transfer with `host_size` 2'b00 (byte) or 2'b11 is dropped without any downstream request. `host_err` is high for exactly the one following cycle.
- R7: A full-word transfer (`host_size`=2'b10) passes straight through: downstream data and read data are the host's 32 bits. It leaves the pairing state and the holding halves untouched.
- R8: Reset clears both pairing states, so a halfword write after reset is always the first of a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host transfer present this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| host_addr | input | HADDR_W (16) | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, same cycle |
| host_err | output | 1 | One-cycle pulse after a refused transfer |
| reg_valid | output | 1 | Downstream request strobe |
| reg_write | output | 1 | Downstream request direction |
| reg_addr | output | REG_AW (8) | Downstream word-aligned address |
| reg_wdata | output | 32 | Downstream write data |
| reg_rdata | input | 32 | Downstream read data, same cycle |

## Verification
Write pairs are tried low-then-high, high-then-low and as two writes to the same half. Together these show that pairing counts transfers rather than expecting an order, and that the combined word takes the latest value of each hold.

An address change in the middle of a pair, and a full-word transfer inserted inside a pair, separate a pairing state that restarts from one that is only disturbed. Upper-address aliases show that the high address bits are ignored.

On the read side, the register is changed between the two reads of a pair. This separates a latched snapshot from a second fetch. Byte transfers and a reset in the middle of a pair cover the refusal and clearing paths.

// File: rtl/hw_pair_bridge.sv
module hw_pair_bridge #(
  parameter int HADDR_W = 16,
  parameter int REG_AW  = 8,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [1:0]         host_size,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_err,
  output logic               reg_valid,
  output logic               reg_write,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [DW-1:0]      reg_wdata,
  input  logic [DW-1:0]      reg_rdata
);
  localparam int HW = DW / 2;

  logic [REG_AW-1:0] offs, aligned;
  logic is_half, is_word, bad, hw_wr, hw_rd, w_same, r_second;
  logic [HW-1:0] lo_nxt, hi_nxt, rd_half;
  logic [DW-1:0] rd_src;

  logic [REG_AW-1:0] w_base, r_base;
  logic              w_odd, r_odd;
  logic [HW-1:0]     w_lo, w_hi;
  logic [DW-1:0]     r_latch;

  assign offs    = host_addr[REG_AW-1:0];
  assign aligned = {offs[REG_AW-1:2], 2'b00};
  assign is_half = host_size == 2'b01;
  assign is_word = host_size == 2'b10;
  assign bad     = host_valid && !is_half && !is_word;
  assign hw_wr   = host_valid && is_half && host_write;
  assign hw_rd   = host_valid && is_half && !host_write;

  assign w_same   = w_odd && (aligned == w_base);
  assign r_second = hw_rd && r_odd && (aligned == r_base);

  assign lo_nxt = offs[1] ? w_lo : host_wdata[HW-1:0];
  assign hi_nxt = offs[1] ? host_wdata[HW-1:0] : w_hi;

  assign reg_valid = host_valid && (is_word || (hw_wr && w_same) || (hw_rd && !r_second));
  assign reg_write = host_write;
  assign reg_addr  = aligned;
  assign reg_wdata = is_word ? host_wdata : {hi_nxt, lo_nxt};

  assign rd_src     = r_second ? r_latch : reg_rdata;
  assign rd_half    = offs[1] ? rd_src[DW-1:HW] : rd_src[HW-1:0];
  assign host_rdata = is_word ? reg_rdata : {{HW{1'b0}}, rd_half};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_odd    <= 1'b0;
      r_odd    <= 1'b0;
      w_base   <= '0;
      r_base   <= '0;
      w_lo     <= '0;
      w_hi     <= '0;
      r_latch  <= '0;
      host_err <= 1'b0;
    end else begin
      host_err <= bad;
      if (hw_wr) begin
        w_base <= aligned;
        w_odd  <= !w_same;
        if (offs[1]) w_hi <= host_wdata[HW-1:0];
        else         w_lo <= host_wdata[HW-1:0];
      end
      if (hw_rd) begin
        r_base <= aligned;
        r_odd  <= !r_second;
        if (!r_second) r_latch <= reg_rdata;
      end
    end
  end
endmodule

// File: rtl/hw_pair_bridge_chk.sv
module hw_pair_bridge_chk #(
  parameter int HADDR_W = 16,
  parameter int REG_AW  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_write,
  input logic [1:0]         host_size,
  input logic [HADDR_W-1:0] host_addr,
  input logic               host_err,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [REG_AW-1:0]  reg_addr
);
  logic [REG_AW-3:0] m_wb, m_rb;
  logic m_wp, m_rp, half, word, refused, hwr, hrd, wpair, rpair;

  assign half    = host_size == 2'b01;
  assign word    = host_size == 2'b10;
  assign refused = host_valid && !half && !word;
  assign hwr     = host_valid && half && host_write;
  assign hrd     = host_valid && half && !host_write;
  assign wpair   = m_wp && (m_wb == host_addr[REG_AW-1:2]);
  assign rpair   = m_rp && (m_rb == host_addr[REG_AW-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wp <= 1'b0; m_rp <= 1'b0; m_wb <= '0; m_rb <= '0;
    end else begin
      if (hwr) begin m_wp <= !wpair; m_wb <= host_addr[REG_AW-1:2]; end
      if (hrd) begin m_rp <= !rpair; m_rb <= host_addr[REG_AW-1:2]; end
    end
  end

  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> reg_addr[1:0] == 2'b00);
  p_wr_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr && wpair) |-> (reg_valid && reg_write));
  p_wr_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr && !wpair) |-> !reg_valid);
  p_rd_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd && !rpair) |-> (reg_valid && !reg_write));
  p_rd_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hrd && rpair) |-> !reg_valid);
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> !reg_valid);
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> host_err);
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> $past(refused));
  p_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && word) |-> (reg_valid && reg_write == host_write));
endmodule

bind hw_pair_bridge hw_pair_bridge_chk #(.HADDR_W(HADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_size(host_size), .host_addr(host_addr), .host_err(host_err),
  .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr)
);

// File: tb/hw_pair_bridge_test.sv
module hw_pair_bridge_test;
  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_write = 0;
  logic [1:0] host_size = 2'b01;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata, reg_wdata, reg_rdata;
  logic host_err, reg_valid, reg_write;
  logic [7:0] reg_addr;

  hw_pair_bridge uut (.*);

  always #2 clk = ~clk;

  logic [31:0] mem [0:63];
  assign reg_rdata = mem[reg_addr[7:2]];
  always @(posedge clk) if (rst_n && reg_valid && reg_write) mem[reg_addr[7:2]] <= reg_wdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [39:0] expq[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && reg_valid && reg_write) begin
      if (expq.size() == 0) chk(0, "R3 unexpected write", {24'h0, reg_addr}, 32'h0);
      else begin
        logic [39:0] e;
        e = expq.pop_front();
        chk({reg_addr, reg_wdata} == e, "R3 write", reg_wdata, e[31:0]);
        chk(reg_addr == e[39:32], "R1 write addr", {24'h0, reg_addr}, {24'h0, e[39:32]});
      end
    end
  end

  logic [15:0] hlo, hhi;
  logic [7:0] wbase, rbase;
  bit wodd, rodd;
  logic [31:0] rlat;
  logic got_v, got_w;
  logic [31:0] got_r;

  task automatic drive(input bit wr, input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1; host_write = wr; host_size = sz; host_addr = a; host_wdata = d;
    #1;
    got_v = reg_valid; got_w = reg_write; got_r = host_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    host_valid = 0;
    #1;
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [15:0] d, input string req);
    logic [7:0] al;
    bit same;
    al = {a[7:2], 2'b00};
    same = wodd && al == wbase;
    if (a[1]) hhi = d; else hlo = d;
    if (same) expq.push_back({al, hhi, hlo});
    drive(1, 2'b01, a, {16'h0, d});
    chk(got_v == same, req, {31'h0, got_v}, {31'h0, same});
    wbase = al; wodd = !same;
  endtask

  task automatic hread(input logic [15:0] a, input string req);
    logic [7:0] al;
    bit same;
    logic [31:0] exp;
    al = {a[7:2], 2'b00};
    same = rodd && al == rbase;
    if (!same) rlat = mem[al[7:2]];
    exp = {16'h0, a[1] ? rlat[31:16] : rlat[15:0]};
    drive(0, 2'b01, a, 32'h0);
    chk(got_v == !same && (same || !got_w), req, {31'h0, got_v}, {31'h0, !same});
    chk(got_r == exp, req, got_r, exp);
    rbase = al; rodd = !same;
  endtask

  task automatic do_reset();
    @(negedge clk);
    host_valid = 0; rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    wodd = 0; rodd = 0; hlo = 0; hhi = 0; wbase = 0; rbase = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA5000000 + i;
    wodd = 0; rodd = 0; hlo = 0; hhi = 0; wbase = 0; rbase = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(!host_err && !reg_valid, "R8 reset state", {30'h0, host_err, reg_valid}, 32'h0);
    rst_n = 1;

    hwrite(16'h0010, 16'h1111, "R3 low first");
    hwrite(16'h0012, 16'h2222, "R3 high second");
    hwrite(16'h0022, 16'h4444, "R3 high first");
    hwrite(16'h0020, 16'h3333, "R3 low second");
    hwrite(16'h0030, 16'hAAAA, "R2 same half first");
    hwrite(16'h0030, 16'hBBBB, "R2 same half second");
    hwrite(16'h0040, 16'h5555, "R4 first");
    hwrite(16'h0044, 16'h6666, "R4 addr change restarts");
    hwrite(16'h0046, 16'h7777, "R4 pair at new addr");
    hwrite(16'h1F50, 16'h0102, "R1 upper bits ignored a");
    hwrite(16'h2F52, 16'h0304, "R1 upper bits ignored b");

    hwrite(16'h0070, 16'hC0DE, "R7 pair open");
    expq.push_back({8'h60, 32'hDEADBEEF});
    drive(1, 2'b10, 16'h0060, 32'hDEADBEEF);
    chk(got_v && got_w, "R7 word write passes", {31'h0, got_v}, 32'h1);
    hwrite(16'h0072, 16'hF00D, "R7 pair survives word write");
    idle();
    drive(0, 2'b10, 16'h0060, 32'h0);
    chk(got_r == 32'hDEADBEEF, "R7 word read", got_r, 32'hDEADBEEF);

    idle();
    hread(16'h0010, "R5 first read fetch");
    @(negedge clk);
    host_valid = 0;
    mem[4] = 32'h99998888;
    hread(16'h0012, "R5 second read from latch");
    hread(16'h0012, "R5 new pair fetches");
    hread(16'h0020, "R4 read first");
    hread(16'h0026, "R4 read addr change restarts");
    hread(16'h0024, "R2 read low half");

    drive(1, 2'b00, 16'h0080, 32'h12345678);
    chk(!got_v, "R6 byte write dropped", {31'h0, got_v}, 32'h0);
    idle();
    chk(host_err, "R6 err pulse", {31'h0, host_err}, 32'h1);
    idle();
    chk(!host_err, "R6 err one cycle", {31'h0, host_err}, 32'h0);
    drive(0, 2'b11, 16'h0080, 32'h0);
    chk(!got_v, "R6 invalid read dropped", {31'h0, got_v}, 32'h0);
    idle();
    chk(host_err, "R6 err on read", {31'h0, host_err}, 32'h1);
    drive(0, 2'b10, 16'h0080, 32'h0);
    chk(got_r == 32'hA5000020, "R6 byte write left register", got_r, 32'hA5000020);

    hwrite(16'h0090, 16'hABCD, "R8 pair open");
    do_reset();
    hwrite(16'h0092, 16'h1234, "R8 reset clears pairing");
    hwrite(16'h0090, 16'h5678, "R8 new pair completes");
    idle();
    idle();
    chk(expq.size() == 0, "R3 all writes seen", expq.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule